// File: doc/BRIEF.md
# Dual-Route Channel Interrupt Controller

This block gathers completion pulses from up to sixteen transfer channels into a single sticky pending register. It then steers them onto two system interrupt lines. Each line has its own enable mask and its own force mask. It also has a masked view of the pending bits, and its interrupt output is the OR of that view. A channel can therefore be serviced by either line, by both lines, or by neither. Software can also raise a line with no channel event at all.

Software reaches the block through a small synchronous register bus, one word per register and one bit per channel. Pending bits are cleared by writing a one to them. The write may go to the raw pending word or to either line's masked word, and every path clears the same shared pending bits. The word addresses are: 0 for raw pending, 1 for line 0 enable, 2 for line 0 force, 3 for line 0 masked, 4 for line 1 enable, 5 for line 1 force and 6 for line 1 masked. Reads return data on the clock edge after `rd_en` is sampled.

Top module: `dma_irq_router`

## Requirements
- R1: After a synchronous reset, the pending, enable and force registers of both lines are zero, both interrupt outputs are low and `rdata` is zero.
- R2: A high `ch_done[n]` at a clock edge sets pending bit n at that edge. The bit then stays set until software clears it.
- R3: A read of word 0 returns the pending bits (bit n is channel n) unaffected by any enable or force setting.
- R4: A write to word 0 clears exactly the pending bits that are 1 in `wdata` and leaves the others unchanged.
- R5: A write to word 3 or word 6 clears the pending bits that are 1 in `wdata`, whatever the enable settings are.
- R6: When a channel pulse and a software clear hit the same bit at the same edge, the bit stays set.
- R7: A read of word 3 (line 0) or word 6 (line 1) returns (pending AND enable) OR force for that line.
- R8: `irq[k]` is a registered level equal to the OR of line k's masked view as it stood one clock earlier.
- R9: Writing a force register (word 2 or 5) leaves the pending bits unchanged.
- R10: The two lines are independent: enabling or forcing a channel on one line does not raise the other line.
- R11: Writes to words 7 and above change no register, and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_done | input | NUM_CH | One-cycle completion pulses, bit n for channel n |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | NUM_CH | Write data |
| rdata | output | NUM_CH | Read data, registered, valid the cycle after `rd_en` |
| irq | output | 2 | Registered interrupt levels, bit k for line k |

## Verification
The hardest case to reach from the ports is a channel pulse that arrives on the same edge as a software clear of that bit. The stimulus drives `ch_done` and a word-0 write on one cycle, with a mask that covers the pulsing bit and one other set bit. A read-back then shows that the pulsing bit survived and the other bit was cleared. The clears made through the masked words are also exercised. One of them is aimed at a bit that the line does not enable, which shows that the clear does not depend on the mask.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
  localparam int unsigned NUM_LINES     = 2;
  localparam int unsigned REGS_PER_LINE = 3;
  localparam int unsigned RAW_WORD      = 0;
  localparam int unsigned LAST_WORD     = RAW_WORD + NUM_LINES * REGS_PER_LINE;

  typedef enum int unsigned {
    FLD_ENABLE = 0,
    FLD_FORCE  = 1,
    FLD_MASKED = 2
  } line_field_e;

  function automatic int unsigned line_word(int unsigned line, line_field_e fld);
    return RAW_WORD + 1 + line * REGS_PER_LINE + int'(fld);
  endfunction
endpackage

// File: rtl/dirq_raw_status.sv
module dirq_raw_status #(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] evt,
  input  logic [NUM_CH-1:0] clr,
  output logic [NUM_CH-1:0] raw_q
);
  // Per-bit update: clear first, new event ORed on top so it wins a collision.
  for (genvar n = 0; n < NUM_CH; n++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        raw_q[n] <= 1'b0;
      end else if (evt[n]) begin
        raw_q[n] <= 1'b1;
      end else if (clr[n]) begin
        raw_q[n] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dirq_line.sv
module dirq_line #(
  parameter int unsigned NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_we,
  input  logic              frc_we,
  input  logic [NUM_CH-1:0] wbits,
  input  logic [NUM_CH-1:0] raw,
  output logic [NUM_CH-1:0] en_q,
  output logic [NUM_CH-1:0] frc_q,
  output logic [NUM_CH-1:0] masked,
  output logic              irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      frc_q <= '0;
    end else begin
      if (en_we)  en_q  <= wbits;
      if (frc_we) frc_q <= wbits;
    end
  end

  always_comb masked = (raw & en_q) | frc_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |masked;
  end
endmodule

// File: rtl/dirq_regbus.sv
module dirq_regbus
  import dirq_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  wr_en,
  input  logic                                  rd_en,
  input  logic [ADDR_W-1:0]                     addr,
  input  logic [NUM_CH-1:0]                     wdata,
  input  logic [NUM_CH-1:0]                     raw,
  input  logic [NUM_LINES-1:0][NUM_CH-1:0]      en,
  input  logic [NUM_LINES-1:0][NUM_CH-1:0]      frc,
  input  logic [NUM_LINES-1:0][NUM_CH-1:0]      masked,
  output logic [NUM_CH-1:0]                     clr_mask,
  output logic [NUM_LINES-1:0]                  en_we,
  output logic [NUM_LINES-1:0]                  frc_we,
  output logic [NUM_CH-1:0]                     rdata
);
  logic [NUM_CH-1:0] rd_mux;

  always_comb begin
    clr_mask = '0;
    en_we    = '0;
    frc_we   = '0;
    if (wr_en) begin
      if (addr == ADDR_W'(RAW_WORD)) clr_mask = wdata;
      for (int l = 0; l < int'(NUM_LINES); l++) begin
        if (addr == ADDR_W'(line_word(l, FLD_ENABLE))) en_we[l]  = 1'b1;
        if (addr == ADDR_W'(line_word(l, FLD_FORCE)))  frc_we[l] = 1'b1;
        if (addr == ADDR_W'(line_word(l, FLD_MASKED))) clr_mask  = wdata;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(RAW_WORD)) rd_mux = raw;
    for (int l = 0; l < int'(NUM_LINES); l++) begin
      if (addr == ADDR_W'(line_word(l, FLD_ENABLE))) rd_mux = en[l];
      if (addr == ADDR_W'(line_word(l, FLD_FORCE)))  rd_mux = frc[l];
      if (addr == ADDR_W'(line_word(l, FLD_MASKED))) rd_mux = masked[l];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/dma_irq_router.sv
module dma_irq_router
  import dirq_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CH-1:0]    ch_done,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_CH-1:0]    wdata,
  output logic [NUM_CH-1:0]    rdata,
  output logic [NUM_LINES-1:0] irq
);
  logic [NUM_CH-1:0]                raw_q;
  logic [NUM_CH-1:0]                clr_mask;
  logic [NUM_LINES-1:0]             en_we;
  logic [NUM_LINES-1:0]             frc_we;
  logic [NUM_LINES-1:0][NUM_CH-1:0] en_q;
  logic [NUM_LINES-1:0][NUM_CH-1:0] frc_q;
  logic [NUM_LINES-1:0][NUM_CH-1:0] masked;

  dirq_raw_status #(.NUM_CH(NUM_CH)) raw_i (
    .clk   (clk),
    .rst   (rst),
    .evt   (ch_done),
    .clr   (clr_mask),
    .raw_q (raw_q)
  );

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    dirq_line #(.NUM_CH(NUM_CH)) line_i (
      .clk    (clk),
      .rst    (rst),
      .en_we  (en_we[k]),
      .frc_we (frc_we[k]),
      .wbits  (wdata),
      .raw    (raw_q),
      .en_q   (en_q[k]),
      .frc_q  (frc_q[k]),
      .masked (masked[k]),
      .irq_q  (irq[k])
    );
  end

  dirq_regbus #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) bus_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .raw      (raw_q),
    .en       (en_q),
    .frc      (frc_q),
    .masked   (masked),
    .clr_mask (clr_mask),
    .en_we    (en_we),
    .frc_we   (frc_we),
    .rdata    (rdata)
  );
endmodule

// File: rtl/dirq_checker.sv
module dirq_checker
  import dirq_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned ADDR_W = 4
) (
  input logic                             clk,
  input logic                             rst,
  input logic [NUM_CH-1:0]                ch_done,
  input logic                             wr_en,
  input logic                             rd_en,
  input logic [ADDR_W-1:0]                addr,
  input logic [NUM_CH-1:0]                rdata,
  input logic [NUM_LINES-1:0]             irq,
  input logic [NUM_CH-1:0]                raw,
  input logic [NUM_LINES-1:0][NUM_CH-1:0] en,
  input logic [NUM_LINES-1:0][NUM_CH-1:0] frc
);
  logic force_wr;
  always_comb begin
    force_wr = 1'b0;
    for (int l = 0; l < int'(NUM_LINES); l++)
      if (wr_en && addr == ADDR_W'(line_word(l, FLD_FORCE))) force_wr = 1'b1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq == '0 && rdata == '0)); // R1

  AST_EVENT_SETS_RAW: assert property (@(posedge clk) disable iff (rst)
    (|ch_done) |=> ((raw & $past(ch_done)) == $past(ch_done))); // R2

  AST_RAW_STICKY: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ((raw & $past(raw)) == $past(raw))); // R2

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(RAW_WORD) && |ch_done) |=> ((raw & $past(ch_done)) == $past(ch_done))); // R6

  AST_FORCE_KEEPS_RAW: assert property (@(posedge clk) disable iff (rst)
    (force_wr && ch_done == '0) |=> $stable(raw)); // R9

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr >= ADDR_W'(LAST_WORD + 1)) |=> (rdata == '0)); // R11

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_irq
    AST_IRQ_FOLLOWS_MASK: assert property (@(posedge clk) disable iff (rst)
      irq[k] == $past(|((raw & en[k]) | frc[k]))); // R8
  end
endmodule

bind dma_irq_router dirq_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .ch_done (ch_done),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .rdata   (rdata),
  .irq     (irq),
  .raw     (raw_q),
  .en      (en_q),
  .frc     (frc_q)
);

// File: tb/dma_irq_router_tb_top.sv
`timescale 1ns/1ps
module dma_irq_router_tb_top;
  localparam int unsigned NCH = 16;
  localparam int unsigned AW  = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] ch_done = '0;
  logic           wr_en = 1'b0;
  logic           rd_en = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [NCH-1:0] wdata = '0;
  logic [NCH-1:0] rdata;
  logic [1:0]     irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic rd_d = 1'b0;

  logic [NCH-1:0] exp_q[$];
  string          tag_q[$];

  always #2 clk = ~clk;

  dma_irq_router #(.NUM_CH(NCH), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .ch_done(ch_done), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always @(posedge clk) rd_d <= rd_en;

  // Monitor: compare each returned read word against the scoreboard.
  always @(negedge clk) begin
    if (rd_d) begin
      logic [NCH-1:0] e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL scoreboard: read data %h with no expected item", rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          failures++;
          $display("FAIL %s: rdata actual=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input int a, input logic [NCH-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [NCH-1:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [NCH-1:0] m);
    @(negedge clk);
    ch_done = m;
    @(negedge clk);
    ch_done = '0;
  endtask

  task automatic chk_irq(input logic [1:0] e, input string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s: irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_irq(2'b00, "R1 irq low after reset");
    for (int a = 0; a < 7; a++) rd(a, '0, "R1 register zero after reset");

    pulse(16'h0005);
    rd(0, 16'h0005, "R2 pulse sets raw bits");
    repeat (5) @(negedge clk);
    rd(0, 16'h0005, "R2 raw bits sticky");
    chk_irq(2'b00, "R8 no enable no irq");

    wr(2, 16'h0100);
    rd(0, 16'h0005, "R9 force write keeps raw");
    rd(3, 16'h0100, "R7 masked0 shows force");
    chk_irq(2'b01, "R10 force on line 0 only");
    wr(2, 16'h0000);
    chk_irq(2'b00, "R8 irq drops after force off");

    wr(1, 16'h0004);
    rd(3, 16'h0004, "R7 masked0 = raw and en0");
    rd(0, 16'h0005, "R3 raw ignores enable");
    chk_irq(2'b01, "R10 enable on line 0 only");
    wr(4, 16'h0001);
    wr(5, 16'h0200);
    rd(6, 16'h0201, "R7 masked1 = raw and en1 or force1");
    rd(0, 16'h0005, "R3 raw ignores force");
    chk_irq(2'b11, "R8 both lines");
    wr(5, 16'h0000);

    wr(0, 16'h0004);
    rd(0, 16'h0001, "R4 raw write clears only mask bits");
    chk_irq(2'b10, "R8 line 0 drops after clear");

    wr(6, 16'h0001);
    rd(0, 16'h0000, "R5 clear through masked1");
    chk_irq(2'b00, "R8 line 1 drops after clear");

    pulse(16'h00F0);
    wr(3, 16'h0030);
    rd(0, 16'h00C0, "R5 clear through masked0 ignores enable");

    @(negedge clk);
    ch_done = 16'h0040; wr_en = 1'b1; addr = AW'(0); wdata = 16'h00C0;
    @(negedge clk);
    ch_done = '0; wr_en = 1'b0;
    rd(0, 16'h0040, "R6 event wins over same-cycle clear");

    wr(9, 16'hFFFF);
    wr(15, 16'hFFFF);
    rd(0, 16'h0040, "R11 unmapped write leaves raw");
    rd(1, 16'h0004, "R11 unmapped write leaves enable");
    rd(9, 16'h0000, "R11 unmapped read zero");
    rd(15, 16'h0000, "R11 unmapped read zero top");

    pulse(16'hFFFF);
    rd(0, 16'hFFFF, "R2 all channels pending");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: %0d reads unanswered expected 0", exp_q.size());
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run incomplete expected completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule